// File: doc/BRIEF.md
# Dual-Channel Compare Timer with Selectable Count Source

This block is an up-counter with two compare channels. Each increment is gated by an enable that can come from one of four places: every system clock, a pulse from either of two neighbouring timers, or edges of an external pin. The pin is synchronized first, and the edge that counts (rising, falling, both or none) is selectable.

Each channel holds a compare value and a mode word. A channel produces a compare event when the count equals its compare value at the moment an increment enable arrives. On that event the mode word decides what happens. The counter can be loaded with zero instead of counting on. The channel's sticky interrupt flag can be set. A shared output flip-flop can be flipped. In single-shot mode the channel acts once and then ignores later matches until its mode word is written again. Both channels export their compare events as one-cycle pulses.

Software programs the block through a plain write port with a 3-bit address.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count is 0, all interrupt flags, the toggle output and the event pulses are 0. Both compare values are 0xFF, both mode words are 0, and the clock-select word is 4'b1111 (system clock, both edges).
- R2: With source code 2'b11 in clock-select bits [1:0], the count rises by one on every clock. Without a reset-on-match action it wraps from 255 to 0.
- R3: Source code 2'b01 counts only the pulses on `pulse_a`, and source code 2'b10 counts only the pulses on `pulse_b`. The unselected pulse input has no effect on the count.
- R4: Source code 2'b00 counts `ext_in` edges after a two-flop synchronizer. Clock-select bits [3:2] pick the edges: 2'b01 counts rising, 2'b10 falling, 2'b11 both, and 2'b00 none.
- R5: A compare event occurs when the count equals the channel's compare value while an increment enable is present. `match_o[i]` is high for one cycle, starting at the same edge that updates the count. Compare value 0xFF is matched when the count is at 255.
- R6: When mode bit 1 (reset action) is set, a compare event makes the counter load 0 instead of incrementing.
- R7: When mode bit 0 (interrupt action) is set, a compare event sets `irq_o[i]`, and the flag holds until software writes a 1 to bit i at address 5. Writing a 0 to a bit leaves that flag unchanged, and a set in the same cycle takes priority over a clear.
- R8: When mode bit 2 (toggle action) is set, a compare event flips `tog_o`. If both channels toggle in the same cycle, the requests combine by XOR and `tog_o` does not change.
- R9: When mode bit 3 (single-shot) is set, only the first compare event of the channel occurs. Later matches produce no pulse and no action until that channel's mode word is written again.
- R10: The write map is: address 0 is clock-select [3:0], address 1+i is the compare value of channel i, address 3+i is the mode word of channel i [3:0], and address 5 is interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| pulse_a | input | 1 | Increment pulse from the first neighbouring timer |
| pulse_b | input | 1 | Increment pulse from the second neighbouring timer |
| ext_in | input | 1 | Asynchronous external count input |
| cnt_val | output | 8 | Current count |
| match_o | output | 2 | Per-channel compare event pulse |
| irq_o | output | 2 | Per-channel sticky interrupt flag |
| tog_o | output | 1 | Shared toggle flip-flop output |

## Verification
A wrong source or edge selection appears on `cnt_val` at the next increment: the count either freezes or advances when it should not. External edges show up three clocks after the pin changes. A corrupted compare value, mode word or single-shot flag is only seen when the count next reaches the compare value, which can take up to 256 increments. At that point it shows as a missing or extra `match_o` pulse, an unexpected `irq_o` or `tog_o` change, or a count that fails to return to zero. For this reason the directed tests drive the count around the whole circle.

// File: rtl/dct_pkg.sv
// Shared types and encodings for the dual-channel compare timer.
// Assumes a count width of at least 4 bits, so that mode words fit in write data.
package dct_pkg;

    // Increment source codes held in clock-select bits [1:0]
    typedef enum logic [1:0] {
        SRC_EXT = 2'b00,
        SRC_A   = 2'b01,
        SRC_B   = 2'b10,
        SRC_SYS = 2'b11
    } src_e;

    // Edge qualification codes held in clock-select bits [3:2]
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    // Per-channel action mask, mode word bits [3:0]
    typedef struct packed {
        logic one_shot;   // bit 3
        logic do_toggle;  // bit 2
        logic do_clear;   // bit 1
        logic do_irq;     // bit 0
    } mode_t;

    localparam logic [3:0] CSEL_RESET = 4'b1111;

endpackage

// File: rtl/dct_clk_sel.sv
// Increment-enable generator: synchronizes the external input, detects the
// chosen edges and selects one of four enable sources.
// Assumes pulse_a and pulse_b are already synchronous one-cycle pulses.
module dct_clk_sel
    import dct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic [1:0] edge_sel,
    input  logic       pulse_a,
    input  logic       pulse_b,
    input  logic       ext_in,
    output logic       inc_en
);

    logic [2:0] ext_sh;
    logic       ext_rise;
    logic       ext_fall;
    logic       ext_tick;

    // Two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[1:0], ext_in};
    end

    assign ext_rise = ext_sh[1] & ~ext_sh[2];
    assign ext_fall = ~ext_sh[1] & ext_sh[2];

    // Qualify detected edges with the programmed edge selection
    always_comb begin
        unique case (edge_e'(edge_sel))
            EDGE_RISE: ext_tick = ext_rise;
            EDGE_FALL: ext_tick = ext_fall;
            EDGE_BOTH: ext_tick = ext_rise | ext_fall;
            default:   ext_tick = 1'b0;
        endcase
    end

    // Four-way source selection of the increment enable
    always_comb begin
        unique case (src_e'(src_sel))
            SRC_SYS: inc_en = 1'b1;
            SRC_B:   inc_en = pulse_b;
            SRC_A:   inc_en = pulse_a;
            default: inc_en = ext_tick;
        endcase
    end

endmodule

// File: rtl/dct_cmp_chan.sv
// One compare channel: compare value, mode word and single-shot state.
// Produces a qualified compare event and the masked action requests.
// Assumes the count and inc_en describe the same cycle.
module dct_cmp_chan
    import dct_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int ADDR_W    = 3,
    parameter int CMP_ADDR  = 1,
    parameter int MODE_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              inc_en,
    output logic              evt,
    output logic              clr_req,
    output logic              irq_req,
    output logic              tog_req
);

    logic [CNT_W-1:0] cmp_q;
    mode_t            mode_q;
    logic             spent_q;
    logic             cmp_wr;
    logic             mode_wr;

    assign cmp_wr  = wr_en && (wr_addr == ADDR_W'(CMP_ADDR));
    assign mode_wr = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));

    // Compare value register, resets to all ones
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (cmp_wr) cmp_q <= wr_data;
    end

    // Mode word register
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= mode_t'(wr_data[3:0]);
    end

    // Event qualification: match at an increment, unless a single shot was used
    assign evt = inc_en && (cnt == cmp_q) && !(mode_q.one_shot && spent_q);

    // Single-shot state: set by the first event, re-armed by a mode write
    always_ff @(posedge clk) begin
        if (!rst_n)                     spent_q <= 1'b0;
        else if (mode_wr)               spent_q <= 1'b0;
        else if (evt && mode_q.one_shot) spent_q <= 1'b1;
    end

    assign clr_req = evt & mode_q.do_clear;
    assign irq_req = evt & mode_q.do_irq;
    assign tog_req = evt & mode_q.do_toggle;

endmodule

// File: rtl/dct_counter.sv
// Up-counter advanced by an increment enable, with a zero-load request that
// replaces the increment. Wraps naturally at the top of its range.
module dct_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             load_zero,
    output logic [CNT_W-1:0] cnt
);

    // Count state: zero-load takes precedence over the increment
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (inc_en) cnt <= load_zero ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/dual_cmp_timer.sv
// Top level: register decode for clock select and interrupt clear, the
// channel array, the counter, the interrupt flags and the toggle flip-flop.
// Assumes a synchronous write port; writes take effect at the next clock edge.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(2 * NUM_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              pulse_a,
    input  logic              pulse_b,
    input  logic              ext_in,
    output logic [CNT_W-1:0]  cnt_val,
    output logic [NUM_CH-1:0] match_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              tog_o
);

    localparam int A_CSEL      = 0;
    localparam int A_CMP_BASE  = 1;
    localparam int A_MODE_BASE = 1 + NUM_CH;
    localparam int A_IRQ_CLR   = 1 + 2 * NUM_CH;

    logic [3:0]        csel_q;
    logic              inc_en;
    logic [NUM_CH-1:0] evt_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] irq_v;
    logic [NUM_CH-1:0] tog_v;
    logic              irq_clr_wr;

    // Clock-select register: edge code [3:2], source code [1:0]
    always_ff @(posedge clk) begin
        if (!rst_n)                                         csel_q <= CSEL_RESET;
        else if (wr_en && wr_addr == ADDR_W'(A_CSEL))       csel_q <= wr_data[3:0];
    end

    dct_clk_sel u_clk_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (csel_q[1:0]),
        .edge_sel (csel_q[3:2]),
        .pulse_a  (pulse_a),
        .pulse_b  (pulse_b),
        .ext_in   (ext_in),
        .inc_en   (inc_en)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        dct_cmp_chan #(
            .CNT_W     (CNT_W),
            .ADDR_W    (ADDR_W),
            .CMP_ADDR  (A_CMP_BASE + ch),
            .MODE_ADDR (A_MODE_BASE + ch)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .cnt     (cnt_val),
            .inc_en  (inc_en),
            .evt     (evt_v[ch]),
            .clr_req (clr_v[ch]),
            .irq_req (irq_v[ch]),
            .tog_req (tog_v[ch])
        );
    end

    dct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (inc_en),
        .load_zero (|clr_v),
        .cnt       (cnt_val)
    );

    assign irq_clr_wr = wr_en && (wr_addr == ADDR_W'(A_IRQ_CLR));

    // Sticky interrupt flags: a set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (irq_v[i])                       irq_o[i] <= 1'b1;
                else if (irq_clr_wr && wr_data[i])  irq_o[i] <= 1'b0;
            end
        end
    end

    // Shared toggle flip-flop: simultaneous requests cancel pairwise
    always_ff @(posedge clk) begin
        if (!rst_n) tog_o <= 1'b0;
        else        tog_o <= tog_o ^ (^tog_v);
    end

    // Registered event pulses, aligned with the count update
    always_ff @(posedge clk) begin
        if (!rst_n) match_o <= '0;
        else        match_o <= evt_v;
    end

endmodule

// File: rtl/dct_chk.sv
// Assertion checker for the dual-channel compare timer, bound to the top.
module dct_chk #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] match,
    input logic [NUM_CH-1:0] irq,
    input logic              tog,
    input logic [3:0]        csel
);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

    // R6
    zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cnt) && cnt == '0) |-> ($past(cnt) == '1) || (|match));

    // R8
    tog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog) |-> (|match));

    // R4
    ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csel == 4'b0000) |=> $stable(cnt));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_irq
        // R7
        irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> match[i]);
    end

endmodule

bind dual_cmp_timer dct_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt_val),
    .match (match_o),
    .irq   (irq_o),
    .tog   (tog_o),
    .csel  (csel_q)
);

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pulse_a = 1'b0;
    logic       pulse_b = 1'b0;
    logic       ext_in = 1'b0;
    logic [7:0] cnt_val;
    logic [1:0] match_o;
    logic [1:0] irq_o;
    logic       tog_o;

    int checks = 0;
    int errors = 0;
    logic [1:0] last_match;

    always #5 clk = ~clk;

    dual_cmp_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pulse_a (pulse_a),
        .pulse_b (pulse_b),
        .ext_in  (ext_in),
        .cnt_val (cnt_val),
        .match_o (match_o),
        .irq_o   (irq_o),
        .tog_o   (tog_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_src(input bit use_b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (use_b) pulse_b = 1'b1; else pulse_a = 1'b1;
            @(negedge clk);
            pulse_a = 1'b0; pulse_b = 1'b0;
            last_match = match_o;
        end
    endtask

    task automatic goto_cnt(input int v);
        int guard = 0;
        while (cnt_val != 8'(v) && guard < 600) begin
            pulse_src(1'b0, 1);
            guard++;
        end
        chk("R3 setup reach count", cnt_val, v);
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_in = 1'b1;
        repeat (6) @(negedge clk);
        ext_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        int guard = 0;
        repeat (3) @(negedge clk);
        chk("R1 count at reset", cnt_val, 0);
        chk("R1 irq at reset", irq_o, 0);
        chk("R1 match at reset", match_o, 0);
        chk("R1 toggle at reset", tog_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 R2 sysclk counting after reset", cnt_val, 1);
        @(negedge clk);
        chk("R2 one step per clock", cnt_val, 2);
        while (cnt_val != 8'hFF && guard < 400) begin @(negedge clk); guard++; end
        @(negedge clk);
        chk("R2 wrap to zero", cnt_val, 0);
        chk("R1 R5 compare reset value 0xFF matched", match_o, 2'b11);
        @(negedge clk);
        chk("R5 pulse lasts one cycle", match_o, 0);
    endtask

    task automatic t_sources();
        int v;
        wr(0, 4'b0001);
        v = cnt_val;
        pulse_src(1'b1, 3);
        chk("R3 pulse_b ignored with source A", cnt_val, v);
        pulse_src(1'b0, 4);
        chk("R3 pulse_a counted", cnt_val, (v + 4) % 256);
        wr(0, 4'b0010);
        v = cnt_val;
        pulse_src(1'b0, 2);
        chk("R3 R10 pulse_a ignored with source B", cnt_val, v);
        pulse_src(1'b1, 2);
        chk("R3 pulse_b counted", cnt_val, (v + 2) % 256);
        wr(0, 4'b0001);
    endtask

    task automatic t_clear_on_match();
        wr(1, 5);
        wr(3, 4'b0010);
        goto_cnt(5);
        pulse_src(1'b0, 1);
        chk("R6 load zero on match", cnt_val, 0);
        chk("R5 match pulse channel 0", last_match, 2'b01);
        chk("R6 no irq without irq bit", irq_o, 0);
        pulse_src(1'b0, 1);
        chk("R5 no match off compare value", last_match, 0);
        chk("R6 counting resumes", cnt_val, 1);
        wr(3, 0);
    endtask

    task automatic t_irq();
        wr(3, 4'b0001);
        goto_cnt(5);
        pulse_src(1'b0, 1);
        chk("R7 irq set on match", irq_o, 2'b01);
        chk("R7 count continues without clear bit", cnt_val, 6);
        pulse_src(1'b0, 3);
        chk("R7 irq sticky", irq_o, 2'b01);
        wr(5, 2'b10);
        chk("R7 clear of other bit leaves flag", irq_o, 2'b01);
        wr(5, 2'b00);
        chk("R7 zero write leaves flag", irq_o, 2'b01);
        wr(5, 2'b01);
        chk("R7 write one clears", irq_o, 0);
        wr(3, 0);
    endtask

    task automatic t_toggle();
        int t;
        wr(1, 10); wr(2, 10);
        wr(3, 4'b0100); wr(4, 4'b0100);
        goto_cnt(10);
        t = tog_o;
        pulse_src(1'b0, 1);
        chk("R8 simultaneous toggles cancel", tog_o, t);
        chk("R5 both channels match", last_match, 2'b11);
        wr(2, 20);
        goto_cnt(10);
        t = tog_o;
        pulse_src(1'b0, 1);
        chk("R8 channel 0 toggles", tog_o, t ^ 1);
        goto_cnt(20);
        t = tog_o;
        pulse_src(1'b0, 1);
        chk("R8 channel 1 toggles", tog_o, t ^ 1);
        wr(3, 0); wr(4, 0);
    endtask

    task automatic t_single();
        wr(1, 30);
        wr(3, 4'b1001);
        wr(5, 2'b11);
        goto_cnt(30);
        pulse_src(1'b0, 1);
        chk("R9 first event acts", irq_o, 2'b01);
        chk("R9 first event pulses", last_match[0], 1);
        wr(5, 2'b01);
        goto_cnt(30);
        pulse_src(1'b0, 1);
        chk("R9 later event suppressed irq", irq_o, 0);
        chk("R9 later event suppressed pulse", last_match[0], 0);
        wr(3, 4'b1001);
        goto_cnt(30);
        pulse_src(1'b0, 1);
        chk("R9 mode write re-arms", irq_o, 2'b01);
        wr(3, 0);
        wr(5, 2'b11);
    endtask

    task automatic t_ext();
        int v;
        wr(0, 4'b0100);
        v = cnt_val;
        ext_pulse();
        chk("R4 rising edges only", cnt_val, (v + 1) % 256);
        wr(0, 4'b1000);
        v = cnt_val;
        ext_pulse();
        chk("R4 falling edges only", cnt_val, (v + 1) % 256);
        wr(0, 4'b1100);
        v = cnt_val;
        ext_pulse();
        chk("R4 both edges", cnt_val, (v + 2) % 256);
        wr(0, 4'b0000);
        v = cnt_val;
        ext_pulse();
        chk("R4 edge code 00 counts nothing", cnt_val, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        last_match = '0;
        t_reset();
        t_sources();
        t_clear_on_match();
        t_irq();
        t_toggle();
        t_single();
        t_ext();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule